// File: doc/BRIEF.md
# 64-bit Global Timebase with Periodic Comparator

This block is a free-running 64-bit up-counter that serves as a shared timebase. It also has a 64-bit compare value that can raise an interrupt. Software reaches it through a plain register port. That port has a write strobe, a byte address, write data whose width equals one counter half, and combinational read data. Software reads the counter as two halves. A consistent 64-bit value comes from reading the upper half, then the lower half, then the upper half again, and repeating if the two upper reads differ. This only works because the carry from the lower half into the upper half lands in the same clock cycle as the wrap.

A match occurs when the comparator is enabled and the counter is at or past the compare value. A match sets a sticky pending flag, which software clears by writing 1. When the pending flag rises with interrupt enable set, the block emits a one-cycle interrupt pulse. With auto-step set, every match advances the compare value by a programmable step, so the block produces periodic ticks from a counter that is never reset. Reconfiguring compare, interrupt or step never disturbs the counter.

Top module: `gtm_global_timer`

## Requirements
- R1: After reset, every mapped register reads zero and `irq_o` is low.
- R2: The counter advances by exactly one per clock while the run bit is set, and holds its value while the run bit is clear.
- R3: When the lower counter half is all ones and the counter advances, the lower half becomes zero and the upper half increments at the same clock edge.
- R4: Writes to the counter low (0x00) and counter high (0x04) offsets leave the counter unchanged.
- R5: The control register at 0x08 holds run in bit 0, compare enable in bit 1, interrupt enable in bit 2 and auto-step in bit 3, and its other bits read zero.
- R6: While compare enable is set and counter >= compare value (64-bit unsigned), the pending flag (bit 0 at 0x0C) is set at the next clock edge. While compare enable is clear, no match is raised.
- R7: Writing 1 to bit 0 at 0x0C clears the pending flag. Writing 0 has no effect. If a match holds in the same cycle as the clear, the flag stays set.
- R8: `irq_o` is high for exactly one cycle, in the cycle in which the pending flag goes from 0 to 1, and only if interrupt enable was set. It gives no pulse while the flag stays set.
- R9: The compare value is written as a low half at 0x10 and a high half at 0x14, and the step value at 0x18. On every match with auto-step set, the compare value grows by the step value, modulo 2^64.
- R10: Reads of any offset outside the seven mapped ones return zero, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | HALF_W | Write data |
| rdata_o | output | HALF_W | Combinational read data for `addr_i` |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with HALF_W set to 8, which makes the counter 16 bits wide with 8-bit halves. With that value the carry from the lower into the upper half comes after 256 clocks, so the same-edge carry can be observed directly at the register port. At the default width of 32 that event would never arrive in a run. The same width keeps the two auto-step periods, which check the compare arithmetic across both halves, within a few hundred cycles.

// File: rtl/gtm_pkg.sv
package gtm_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CMP_LO = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CMP_HI = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_STEP   = 5'h18;

  // Control bits, LSB first: run, compare enable, interrupt enable, auto-step
  typedef struct packed {
    logic auto_step;
    logic irq_en;
    logic cmp_en;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/gtm_rst_sync.sv
module gtm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = shift_q[STAGES-1];
endmodule

// File: rtl/gtm_counter.sv
module gtm_counter #(
  parameter  int HALF_W = 32,
  localparam int CNT_W  = 2 * HALF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [HALF_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              lo_wrap;

  always_comb begin
    lo_wrap = (lo_q == '1);
    lo_d    = lo_q + HALF_W'(1);
    hi_d    = lo_wrap ? hi_q + HALF_W'(1) : hi_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (run_i) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt_o = {hi_q, lo_q};

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_o));

  // R3
  cnt_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (cnt_o[HALF_W-1:0] == '1)) |=>
      ((cnt_o[HALF_W-1:0] == '0) &&
       (cnt_o[CNT_W-1:HALF_W] == $past(cnt_o[CNT_W-1:HALF_W]) + HALF_W'(1))));
endmodule

// File: rtl/gtm_compare.sv
module gtm_compare #(
  parameter  int HALF_W = 32,
  localparam int CNT_W  = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_en_i,
  input  logic              irq_en_i,
  input  logic              auto_step_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic              wr_cmp_lo_i,
  input  logic              wr_cmp_hi_i,
  input  logic              wr_step_i,
  input  logic              clr_pend_i,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [HALF_W-1:0] step_o,
  output logic              pend_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]  cmp_q, cmp_d;
  logic [HALF_W-1:0] step_q;
  logic              pend_q, pend_d;
  logic              irq_q, irq_d;
  logic              match, do_step, cmp_load;

  // Match is the unsigned reach-or-pass test on the full width
  always_comb begin
    match    = cmp_en_i && (cnt_i >= cmp_q);
    do_step  = match && auto_step_i;
    cmp_load = do_step || wr_cmp_lo_i || wr_cmp_hi_i;

    cmp_d = cmp_q;
    if (do_step) cmp_d = cmp_q + {{HALF_W{1'b0}}, step_q};
    if (wr_cmp_lo_i) cmp_d[HALF_W-1:0]     = wdata_i;
    if (wr_cmp_hi_i) cmp_d[CNT_W-1:HALF_W] = wdata_i;

    pend_d = pend_q;
    if (clr_pend_i) pend_d = 1'b0;
    if (match)      pend_d = 1'b1;

    irq_d = match && !pend_q && irq_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '0;
    else if (cmp_load) cmp_q <= cmp_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        step_q <= '0;
    else if (wr_step_i) step_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign cmp_o  = cmp_q;
  assign step_o = step_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  // R6
  pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_pend_i) |=> pend_q);

  // R6
  no_match_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_en_i && !pend_q) |=> !pend_q);

  // R8
  irq_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (pend_q && !$past(pend_q) && $past(irq_en_i)));

  // R8
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);

  // R9
  cmp_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_i && auto_step_i && (cnt_i >= cmp_q) && !wr_cmp_lo_i && !wr_cmp_hi_i) |=>
      (cmp_q == $past(cmp_q) + {{HALF_W{1'b0}}, $past(step_q)}));
endmodule

// File: rtl/gtm_regif.sv
module gtm_regif
  import gtm_pkg::*;
#(
  parameter  int HALF_W = 32,
  localparam int CNT_W  = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cmp_i,
  input  logic [HALF_W-1:0] step_i,
  input  logic              pend_i,
  output ctrl_t             ctrl_o,
  output logic [HALF_W-1:0] wdata_o,
  output logic              wr_cmp_lo_o,
  output logic              wr_cmp_hi_o,
  output logic              wr_step_o,
  output logic              clr_pend_o,
  output logic [HALF_W-1:0] rdata_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  wr_ctrl;

  always_comb begin
    wr_ctrl     = wr_en_i && (addr_i == OFS_CTRL);
    wr_cmp_lo_o = wr_en_i && (addr_i == OFS_CMP_LO);
    wr_cmp_hi_o = wr_en_i && (addr_i == OFS_CMP_HI);
    wr_step_o   = wr_en_i && (addr_i == OFS_STEP);
    clr_pend_o  = wr_en_i && (addr_i == OFS_STAT) && wdata_i[0];
    ctrl_d      = ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  always_comb begin
    unique case (addr_i)
      OFS_CNT_LO: rdata_o = cnt_i[HALF_W-1:0];
      OFS_CNT_HI: rdata_o = cnt_i[CNT_W-1:HALF_W];
      OFS_CTRL:   rdata_o = {{(HALF_W-CTRL_W){1'b0}}, ctrl_q};
      OFS_STAT:   rdata_o = {{(HALF_W-1){1'b0}}, pend_i};
      OFS_CMP_LO: rdata_o = cmp_i[HALF_W-1:0];
      OFS_CMP_HI: rdata_o = cmp_i[CNT_W-1:HALF_W];
      OFS_STEP:   rdata_o = step_i;
      default:    rdata_o = '0;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign wdata_o = wdata_i;

  // R5
  ctrl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (addr_i == OFS_CTRL)) |=> $stable(ctrl_o));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > OFS_STEP) |-> (rdata_o == '0));
endmodule

// File: rtl/gtm_global_timer.sv
module gtm_global_timer
  import gtm_pkg::*;
#(
  parameter  int HALF_W = 32,
  localparam int CNT_W  = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              rst_n_int;
  ctrl_t             ctrl;
  logic [CNT_W-1:0]  cnt, cmp;
  logic [HALF_W-1:0] step, wdata;
  logic              pend, wr_cmp_lo, wr_cmp_hi, wr_step, clr_pend;

  gtm_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  gtm_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .run_i  (ctrl.run),
    .cnt_o  (cnt)
  );

  gtm_regif #(.HALF_W(HALF_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .cnt_i       (cnt),
    .cmp_i       (cmp),
    .step_i      (step),
    .pend_i      (pend),
    .ctrl_o      (ctrl),
    .wdata_o     (wdata),
    .wr_cmp_lo_o (wr_cmp_lo),
    .wr_cmp_hi_o (wr_cmp_hi),
    .wr_step_o   (wr_step),
    .clr_pend_o  (clr_pend),
    .rdata_o     (rdata_o)
  );

  gtm_compare #(.HALF_W(HALF_W)) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .cmp_en_i    (ctrl.cmp_en),
    .irq_en_i    (ctrl.irq_en),
    .auto_step_i (ctrl.auto_step),
    .cnt_i       (cnt),
    .wdata_i     (wdata),
    .wr_cmp_lo_i (wr_cmp_lo),
    .wr_cmp_hi_i (wr_cmp_hi),
    .wr_step_i   (wr_step),
    .clr_pend_i  (clr_pend),
    .cmp_o       (cmp),
    .step_o      (step),
    .pend_o      (pend),
    .irq_o       (irq_o)
  );
endmodule

// File: tb/gtm_global_timer_tb_top.sv
module gtm_global_timer_tb_top;
  localparam int HW = 8;
  localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08, A_STA = 5'h0C,
                         A_MLO = 5'h10, A_MHI = 5'h14, A_STP = 5'h18, A_BAD = 5'h1C;

  logic          clk, rst_n, wr_en;
  logic [4:0]    addr;
  logic [HW-1:0] wdata, rdata;
  logic          irq;
  int            checks, errors;

  gtm_global_timer #(.HALF_W(HW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {addr, write data, expected readback, requirement number}
  localparam logic [24:0] VEC [0:8] = '{
    {A_CTL, 8'hFC, 8'h0C, 4'd5},  // R5 upper bits dropped
    {A_CTL, 8'hF0, 8'h00, 4'd5},  // R5
    {A_MLO, 8'h5A, 8'h5A, 4'd9},  // R9
    {A_MHI, 8'hA5, 8'hA5, 4'd9},  // R9
    {A_STP, 8'h33, 8'h33, 4'd9},  // R9
    {A_CLO, 8'h77, 8'h00, 4'd4},  // R4
    {A_CHI, 8'h12, 8'h00, 4'd4},  // R4
    {A_BAD, 8'h99, 8'h00, 4'd10}, // R10
    {A_STA, 8'h01, 8'h00, 4'd7}   // R7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [HW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [HW-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 300 && !seen; i++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [HW-1:0] a, b, h;
    logic [15:0]   base;
    bit            seen, hit;
    checks = 0; errors = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    foreach (VEC[i]) begin
      bus_rd(VEC[i][24:20], a);
      chk("R1", a, 0);
      #1;
    end
    chk("R1", irq, 0);

    // table walk: write then read back
    foreach (VEC[i]) begin
      bus_wr(VEC[i][24:20], VEC[i][19:12]);
      bus_rd(VEC[i][24:20], a);
      chk($sformatf("R%0d", VEC[i][3:0]), a, VEC[i][11:4]);
    end

    // R2 counting and holding
    bus_wr(A_CTL, 8'h01);
    bus_rd(A_CLO, a);
    repeat (5) @(negedge clk);
    bus_rd(A_CLO, b);
    chk("R2", b, a + 8'd5);
    bus_wr(A_CTL, 8'h00);
    bus_rd(A_CLO, a);
    repeat (5) @(negedge clk);
    bus_rd(A_CLO, b);
    chk("R2", b, a);

    // R3 carry at the lower-half wrap
    bus_wr(A_CTL, 8'h01);
    hit = 1'b0;
    h = '0;
    for (int i = 0; i < 600 && !hit; i++) begin
      @(negedge clk);
      bus_rd(A_CLO, a);
      if (a == 8'hFF) begin
        bus_rd(A_CHI, h);
        hit = 1'b1;
      end
    end
    chk("R3", hit, 1);
    @(negedge clk);
    bus_rd(A_CLO, a);
    chk("R3", a, 8'h00);
    bus_rd(A_CHI, b);
    chk("R3", b, h + 8'd1);
    bus_wr(A_CTL, 8'h00);

    // R6, R7, R8 with a stopped counter equal to compare
    bus_rd(A_CLO, a);
    bus_rd(A_CHI, h);
    bus_wr(A_MLO, a);
    bus_wr(A_MHI, h);
    repeat (3) @(negedge clk);
    bus_rd(A_STA, b);
    chk("R6", b, 0);
    bus_wr(A_CTL, 8'h06);
    bus_rd(A_STA, b);
    chk("R6", b, 0);
    chk("R8", irq, 0);
    @(negedge clk);
    bus_rd(A_STA, b);
    chk("R6", b, 1);
    chk("R8", irq, 1);
    @(negedge clk);
    chk("R8", irq, 0);
    bus_wr(A_STA, 8'h00);
    bus_rd(A_STA, b);
    chk("R7", b, 1);
    bus_wr(A_STA, 8'h01);
    bus_rd(A_STA, b);
    chk("R7", b, 1);
    bus_wr(A_CTL, 8'h04);
    bus_wr(A_STA, 8'h01);
    bus_rd(A_STA, b);
    chk("R7", b, 0);
    chk("R8", irq, 0);
    bus_wr(A_CTL, 8'h02);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8", irq, 0);
    end
    bus_rd(A_STA, b);
    chk("R8", b, 1);
    bus_wr(A_CTL, 8'h00);
    bus_wr(A_STA, 8'h01);
    bus_rd(A_STA, b);
    chk("R7", b, 0);

    // R9 periodic matches with auto-step
    base = {h, a};
    bus_wr(A_MLO, 8'(base + 16'd20));
    bus_wr(A_MHI, 8'((base + 16'd20) >> 8));
    bus_wr(A_STP, 8'd30);
    bus_wr(A_CTL, 8'h0F);
    wait_irq(seen);
    chk("R9", seen, 1);
    bus_rd(A_CLO, a);
    chk("R9", a, 8'(base + 16'd21));
    bus_rd(A_MLO, a);
    bus_rd(A_MHI, b);
    chk("R9", {b, a}, base + 16'd50);
    bus_wr(A_STA, 8'h01);
    wait_irq(seen);
    chk("R8", seen, 1);
    bus_rd(A_CLO, a);
    chk("R9", a, 8'(base + 16'd51));
    bus_rd(A_MLO, a);
    bus_rd(A_MHI, b);
    chk("R9", {b, a}, base + 16'd80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule